// File: doc/BRIEF.md
# Boundary-Scan Cell Chain

This block places a serial chain of test cells between a device's core logic and its pads. Each pad owns three cells: one on the inbound path (pad toward core), one on the outbound data path and one on the output-enable path. Every cell has a shift stage, which the chain links from `scan_in` to `scan_out`, and an update stage, which holds the value applied when test mode takes over a path. A test access port controller supplies the clock, the one-cycle capture, shift and update strobes and a decoded two-bit instruction. That controller sits outside this block.

Four instruction codes set the behaviour. With the chain deselected, every path is functional and the strobes have no effect. In observe/preload mode the device keeps running while the pad and core signals are captured and shifted out, and new values are loaded into the update stages. In external-drive mode the update stages drive the pads' data and enable. In internal-drive mode they drive the core's inputs, and the pads stay functional. Because the update stages keep their contents when the instruction changes, a value preloaded in observe mode reaches the pads as soon as external-drive mode is selected.

The serial stream is a plain bit per clock, qualified by the shift strobe and the instruction. There is no back-pressure: the controller paces every transfer. `scan_out` comes straight from the last shift stage, and the controller retimes it for its serial output.

Top module: `bscan_chain`

## Requirements
- R1: While `trst_n` is low, all shift and update stages clear asynchronously to 0, so `scan_out` is 0.
- R2: With instruction code 0 (deselected), `pad_out`=`core_out`, `pad_oe`=`core_oe` and `core_in`=`pad_in`. Capture, shift and update strobes change no shift or update stage.
- R3: A capture edge with a nonzero code loads cell 3p with `pad_in[p]`, cell 3p+1 with `core_out[p]` and cell 3p+2 with `core_oe[p]`. Cell 0 is the one nearest `scan_out`.
- R4: A shift edge with a nonzero code moves every cell one place toward `scan_out` and loads `scan_in` into cell 3·NUM_PINS−1. `scan_out` shows cell 0, so a bit entering `scan_in` appears on `scan_out` after 3·NUM_PINS shift edges.
- R5: An update edge with a nonzero code copies every shift stage into its update stage. At all other edges the update stages hold their value.
- R6: With code 1 (observe/preload), all three functional paths stay as in R2 while capture, shift and update operate.
- R7: With code 2 (external drive), `pad_out[p]` equals update cell 3p+1 and `pad_oe[p]` equals update cell 3p+2, while `core_in` still follows `pad_in`.
- R8: With code 3 (internal drive), `core_in[p]` equals update cell 3p, while the pads follow the core.
- R9: Strobes arriving on the same edge resolve as capture over shift over update.
- R10: Values loaded into the update stages under code 1 appear on the pads as soon as code 2 is selected, with no further update edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; all state changes on its rising edge |
| trst_n | input | 1 | Asynchronous active-low test reset |
| instr | input | 2 | Decoded instruction: 0 off, 1 observe/preload, 2 external drive, 3 internal drive |
| capture_en | input | 1 | Capture strobe from the controller |
| shift_en | input | 1 | Shift strobe from the controller |
| update_en | input | 1 | Update strobe from the controller |
| scan_in | input | 1 | Serial data into the far end of the chain |
| scan_out | output | 1 | Serial data from cell 0 |
| core_out | input | NUM_PINS | Functional output data from the core |
| core_oe | input | NUM_PINS | Functional output enables from the core |
| core_in | output | NUM_PINS | Inbound data presented to the core |
| pad_in | input | NUM_PINS | Values received at the pads |
| pad_out | output | NUM_PINS | Data driven to the pads |
| pad_oe | output | NUM_PINS | Output enables driven to the pads |

## Verification
The hardest behaviours to reach from the ports are those that leave no direct trace. One is an update stage that was not rewritten. Another is a strobe combination that a normal controller never issues. The bench reveals update-stage contents by switching the instruction to a drive mode with no strobe active, so the latched values show on the pads or the core inputs. It also raises capture with shift, and shift with update, on the same edge. It chooses pad and core values so that each priority outcome leaves a different bit on `scan_out` or a different pad pattern.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

  typedef enum logic [1:0] {
    BS_OFF    = 2'd0,
    BS_SAMPLE = 2'd1,
    BS_EXTEST = 2'd2,
    BS_INTEST = 2'd3
  } bs_instr_e;

  typedef enum logic [1:0] {
    OP_HOLD    = 2'd0,
    OP_CAPTURE = 2'd1,
    OP_SHIFT   = 2'd2,
    OP_UPDATE  = 2'd3
  } bs_op_e;

  localparam int CELLS_PER_PIN = 3;
  localparam int CELL_IN       = 0;
  localparam int CELL_DO       = 1;
  localparam int CELL_OE       = 2;

endpackage

// File: rtl/bscan_ctrl.sv
module bscan_ctrl
  import bscan_pkg::*;
(
  input  logic [1:0] instr,
  input  logic       capture_en,
  input  logic       shift_en,
  input  logic       update_en,
  output bs_op_e     op,
  output logic       drive_pads,
  output logic       drive_core
);

  bs_instr_e sel;

  always_comb begin
    sel = bs_instr_e'(instr);
    op  = OP_HOLD;
    if (sel != BS_OFF) begin
      if (capture_en)     op = OP_CAPTURE;
      else if (shift_en)  op = OP_SHIFT;
      else if (update_en) op = OP_UPDATE;
    end
    drive_pads = (sel == BS_EXTEST);
    drive_core = (sel == BS_INTEST);
  end

endmodule

// File: rtl/bscan_shift_chain.sv
module bscan_shift_chain
  import bscan_pkg::*;
#(
  parameter int LEN = 12
) (
  input  logic           tck,
  input  logic           trst_n,
  input  bs_op_e         op,
  input  logic [LEN-1:0] cap_vec,
  input  logic           scan_in,
  output logic [LEN-1:0] shift_q,
  output logic           scan_out
);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      shift_q <= '0;
    end else begin
      case (op)
        OP_CAPTURE: shift_q <= cap_vec;
        OP_SHIFT:   shift_q <= {scan_in, shift_q[LEN-1:1]};
        default:    shift_q <= shift_q;
      endcase
    end
  end

  assign scan_out = shift_q[0];

endmodule

// File: rtl/bscan_update_bank.sv
module bscan_update_bank
  import bscan_pkg::*;
#(
  parameter int LEN = 12
) (
  input  logic           tck,
  input  logic           trst_n,
  input  bs_op_e         op,
  input  logic [LEN-1:0] shift_q,
  output logic [LEN-1:0] upd_q
);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)               upd_q <= '0;
    else if (op == OP_UPDATE)  upd_q <= shift_q;
  end

endmodule

// File: rtl/bscan_pin_mux.sv
module bscan_pin_mux
  import bscan_pkg::*;
#(
  parameter int NUM_PINS = 4,
  localparam int LEN     = NUM_PINS * CELLS_PER_PIN
) (
  input  logic                drive_pads,
  input  logic                drive_core,
  input  logic [LEN-1:0]      upd_q,
  input  logic [NUM_PINS-1:0] core_out,
  input  logic [NUM_PINS-1:0] core_oe,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_PINS-1:0] core_in,
  output logic [LEN-1:0]      cap_vec
);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int BASE = p * CELLS_PER_PIN;

    // each cell observes the functional signal entering it
    assign cap_vec[BASE+CELL_IN] = pad_in[p];
    assign cap_vec[BASE+CELL_DO] = core_out[p];
    assign cap_vec[BASE+CELL_OE] = core_oe[p];

    assign pad_out[p] = drive_pads ? upd_q[BASE+CELL_DO] : core_out[p];
    assign pad_oe[p]  = drive_pads ? upd_q[BASE+CELL_OE] : core_oe[p];
    assign core_in[p] = drive_core ? upd_q[BASE+CELL_IN] : pad_in[p];
  end

endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
  import bscan_pkg::*;
#(
  parameter int NUM_PINS = 8,
  localparam int LEN     = NUM_PINS * CELLS_PER_PIN
) (
  input  logic                tck,
  input  logic                trst_n,
  input  logic [1:0]          instr,
  input  logic                capture_en,
  input  logic                shift_en,
  input  logic                update_en,
  input  logic                scan_in,
  output logic                scan_out,
  input  logic [NUM_PINS-1:0] core_out,
  input  logic [NUM_PINS-1:0] core_oe,
  output logic [NUM_PINS-1:0] core_in,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe
);

  bs_op_e         op;
  logic           drive_pads;
  logic           drive_core;
  logic [LEN-1:0] cap_vec;
  logic [LEN-1:0] shift_q;
  logic [LEN-1:0] upd_q;

  bscan_ctrl u_ctrl (
    .instr      (instr),
    .capture_en (capture_en),
    .shift_en   (shift_en),
    .update_en  (update_en),
    .op         (op),
    .drive_pads (drive_pads),
    .drive_core (drive_core)
  );

  bscan_shift_chain #(.LEN(LEN)) u_shift (
    .tck      (tck),
    .trst_n   (trst_n),
    .op       (op),
    .cap_vec  (cap_vec),
    .scan_in  (scan_in),
    .shift_q  (shift_q),
    .scan_out (scan_out)
  );

  bscan_update_bank #(.LEN(LEN)) u_upd (
    .tck     (tck),
    .trst_n  (trst_n),
    .op      (op),
    .shift_q (shift_q),
    .upd_q   (upd_q)
  );

  bscan_pin_mux #(.NUM_PINS(NUM_PINS)) u_mux (
    .drive_pads (drive_pads),
    .drive_core (drive_core),
    .upd_q      (upd_q),
    .core_out   (core_out),
    .core_oe    (core_oe),
    .pad_in     (pad_in),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe),
    .core_in    (core_in),
    .cap_vec    (cap_vec)
  );

endmodule

// File: rtl/bscan_chain_chk.sv
module bscan_chain_chk #(
  parameter int NUM_PINS = 8,
  localparam int LEN     = NUM_PINS * 3
) (
  input logic                tck,
  input logic                trst_n,
  input logic [1:0]          instr,
  input logic                capture_en,
  input logic                shift_en,
  input logic                update_en,
  input logic                scan_in,
  input logic [NUM_PINS-1:0] core_out,
  input logic [NUM_PINS-1:0] core_oe,
  input logic [NUM_PINS-1:0] core_in,
  input logic [NUM_PINS-1:0] pad_in,
  input logic [NUM_PINS-1:0] pad_out,
  input logic [NUM_PINS-1:0] pad_oe,
  input logic [LEN-1:0]      shift_q,
  input logic [LEN-1:0]      upd_q
);

  logic           active;
  logic           upd_only;
  logic [LEN-1:0] cap_exp;
  logic [NUM_PINS-1:0] ext_do, ext_oe, int_in;

  always_comb begin
    active   = (instr != 2'd0);
    upd_only = active && update_en && !capture_en && !shift_en;
    for (int p = 0; p < NUM_PINS; p++) begin
      cap_exp[3*p]   = pad_in[p];
      cap_exp[3*p+1] = core_out[p];
      cap_exp[3*p+2] = core_oe[p];
      int_in[p]      = upd_q[3*p];
      ext_do[p]      = upd_q[3*p+1];
      ext_oe[p]      = upd_q[3*p+2];
    end
  end

  assert_idle_frozen_R2: assert property (@(posedge tck) disable iff (!trst_n)
    !active |=> ($stable(shift_q) && $stable(upd_q)));

  assert_capture_load_R3: assert property (@(posedge tck) disable iff (!trst_n)
    (active && capture_en) |=> (shift_q == $past(cap_exp)));

  assert_shift_step_R4: assert property (@(posedge tck) disable iff (!trst_n)
    (active && shift_en && !capture_en) |=>
      (shift_q == {$past(scan_in), $past(shift_q[LEN-1:1])}));

  assert_update_load_R5: assert property (@(posedge tck) disable iff (!trst_n)
    upd_only |=> (upd_q == $past(shift_q)));

  assert_update_hold_R5: assert property (@(posedge tck) disable iff (!trst_n)
    !upd_only |=> $stable(upd_q));

  // covers R2 and R6: functional paths in modes 0 and 1
  assert_functional_R6: assert property (@(posedge tck) disable iff (!trst_n)
    (instr[1] == 1'b0) |-> (pad_out == core_out && pad_oe == core_oe && core_in == pad_in));

  assert_extest_drive_R7: assert property (@(posedge tck) disable iff (!trst_n)
    (instr == 2'd2) |-> (pad_out == ext_do && pad_oe == ext_oe && core_in == pad_in));

  assert_intest_drive_R8: assert property (@(posedge tck) disable iff (!trst_n)
    (instr == 2'd3) |-> (core_in == int_in && pad_out == core_out && pad_oe == core_oe));

  assert_capture_beats_update_R9: assert property (@(posedge tck) disable iff (!trst_n)
    (active && capture_en && update_en) |=> $stable(upd_q));

endmodule

bind bscan_chain bscan_chain_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .tck        (tck),
  .trst_n     (trst_n),
  .instr      (instr),
  .capture_en (capture_en),
  .shift_en   (shift_en),
  .update_en  (update_en),
  .scan_in    (scan_in),
  .core_out   (core_out),
  .core_oe    (core_oe),
  .core_in    (core_in),
  .pad_in     (pad_in),
  .pad_out    (pad_out),
  .pad_oe     (pad_oe),
  .shift_q    (shift_q),
  .upd_q      (upd_q)
);

// File: tb/bscan_chain_bench.sv
module bscan_chain_bench;
  localparam int NP  = 4;
  localparam int LEN = 3 * NP;
  localparam logic [LEN-1:0] PAT = 12'hB2E;

  logic tck = 1'b0;
  always #5 tck = ~tck;

  logic          trst_n = 1'b0;
  logic [1:0]    instr  = 2'd0;
  logic          cap = 1'b0, sh = 1'b0, up = 1'b0, si = 1'b0;
  logic [NP-1:0] core_out = 4'b1001, core_oe = 4'b0101, pad_in = 4'b0110;
  logic          scan_out;
  logic [NP-1:0] core_in, pad_out, pad_oe;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  bscan_chain #(.NUM_PINS(NP)) u_bscan_chain (
    .tck(tck), .trst_n(trst_n), .instr(instr),
    .capture_en(cap), .shift_en(sh), .update_en(up),
    .scan_in(si), .scan_out(scan_out),
    .core_out(core_out), .core_oe(core_oe), .core_in(core_in),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  bit            q[$];
  logic [LEN-1:0] upd_m = '0;

  function automatic bit cap_bit(int i);
    case (i % 3)
      0:       return pad_in[i/3];
      1:       return core_out[i/3];
      default: return core_oe[i/3];
    endcase
  endfunction

  function automatic string mode_tag(logic [1:0] m);
    case (m)
      2'd0:    return "R2";
      2'd1:    return "R6";
      2'd2:    return "R7";
      default: return "R8";
    endcase
  endfunction

  always @(posedge tck) begin
    if (!trst_n) begin
      q = {};
      for (int i = 0; i < LEN; i++) q.push_back(1'b0);
      upd_m = '0;
    end else if (instr != 2'd0) begin
      if (cap) begin
        q = {};
        for (int i = 0; i < LEN; i++) q.push_back(cap_bit(i));
      end else if (sh) begin
        void'(q.pop_front());
        q.push_back(si);
      end else if (up) begin
        for (int i = 0; i < LEN; i++) upd_m[i] = q[i];
      end
    end
    #2;
    begin
      logic [NP-1:0] e_po, e_oe, e_ci;
      for (int p = 0; p < NP; p++) begin
        e_po[p] = (instr == 2'd2) ? upd_m[3*p+1] : core_out[p];
        e_oe[p] = (instr == 2'd2) ? upd_m[3*p+2] : core_oe[p];
        e_ci[p] = (instr == 2'd3) ? upd_m[3*p]   : pad_in[p];
      end
      chk("R4 scan_out", 32'(scan_out), 32'(q[0]));
      chk({mode_tag(instr), " pad_out"}, 32'(pad_out), 32'(e_po));
      chk({mode_tag(instr), " pad_oe"},  32'(pad_oe),  32'(e_oe));
      chk({mode_tag(instr), " core_in"}, 32'(core_in), 32'(e_ci));
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick(bit c, bit s, bit u, bit d);
    @(negedge tck);
    cap = c; sh = s; up = u; si = d;
  endtask

  function automatic logic [NP-1:0] field(logic [LEN-1:0] v, int off);
    logic [NP-1:0] r;
    for (int p = 0; p < NP; p++) r[p] = v[3*p+off];
    return r;
  endfunction

  initial begin
    logic [LEN-1:0] exp_cap;

    repeat (2) @(negedge tck);
    chk("R1 scan_out in reset", 32'(scan_out), 32'd0);
    chk("R1 pad_out functional in reset", 32'(pad_out), 32'(core_out));
    @(negedge tck);
    trst_n = 1'b1;

    // R2: deselected, strobes ignored
    pad_in = 4'b0011; core_out = 4'b1010; core_oe = 4'b0110;
    tick(1, 0, 0, 0);
    tick(0, 1, 0, 1);
    tick(0, 1, 0, 1);
    tick(0, 0, 1, 0);
    tick(0, 0, 0, 0);
    chk("R2 scan_out unchanged", 32'(scan_out), 32'd0);
    chk("R2 pad_out", 32'(pad_out), 32'(core_out));
    chk("R2 core_in", 32'(core_in), 32'(pad_in));
    instr = 2'd2;
    #1;
    chk("R2 update stage untouched (pad_out)", 32'(pad_out), 32'd0);
    chk("R2 update stage untouched (pad_oe)", 32'(pad_oe), 32'd0);

    // R3/R4: observe, capture and shift out, shift PAT in
    @(negedge tck);
    instr = 2'd1;
    pad_in = 4'b1101; core_out = 4'b0110; core_oe = 4'b1001;
    for (int p = 0; p < NP; p++) begin
      exp_cap[3*p]   = pad_in[p];
      exp_cap[3*p+1] = core_out[p];
      exp_cap[3*p+2] = core_oe[p];
    end
    cap = 1'b1;
    for (int k = 0; k < LEN; k++) begin
      @(negedge tck);
      chk("R3 captured bit on scan_out", 32'(scan_out), 32'(exp_cap[k]));
      cap = 1'b0; sh = 1'b1; si = PAT[k];
    end
    tick(0, 0, 1, 0);
    tick(0, 0, 0, 0);
    chk("R4 first shifted bit reached scan_out", 32'(scan_out), 32'(PAT[0]));
    chk("R6 pad_out functional after preload", 32'(pad_out), 32'(core_out));
    chk("R6 core_in functional after preload", 32'(core_in), 32'(pad_in));

    // R10/R7: switch to external drive, no update edge
    instr = 2'd2;
    #1;
    chk("R10 preloaded pad_out", 32'(pad_out), 32'(field(PAT, 1)));
    chk("R10 preloaded pad_oe", 32'(pad_oe), 32'(field(PAT, 2)));
    chk("R7 core_in follows pad_in", 32'(core_in), 32'(pad_in));

    // R5: shift ~PAT without update, pads hold
    for (int k = 0; k < LEN; k++) tick(0, 1, 0, ~PAT[k]);
    tick(0, 0, 0, 0);
    chk("R5 update stage holds during shift", 32'(pad_out), 32'(field(PAT, 1)));
    tick(0, 0, 1, 0);
    tick(0, 0, 0, 0);
    chk("R5 R7 pad_out after update", 32'(pad_out), 32'(field(~PAT, 1)));
    chk("R7 pad_oe after update", 32'(pad_oe), 32'(field(~PAT, 2)));

    // R8: internal drive
    instr = 2'd3;
    #1;
    chk("R8 core_in from update stage", 32'(core_in), 32'(field(~PAT, 0)));
    chk("R8 pad_out functional", 32'(pad_out), 32'(core_out));

    // R9: capture beats shift, shift beats update
    @(negedge tck);
    instr = 2'd1;
    tick(1, 1, 0, 0);
    tick(0, 0, 0, 0);
    chk("R9 capture wins over shift", 32'(scan_out), 32'(pad_in[0]));
    tick(0, 1, 1, 1);
    tick(1, 0, 1, 0);
    tick(0, 0, 0, 0);
    instr = 2'd2;
    #1;
    chk("R9 update suppressed by shift/capture", 32'(pad_out), 32'(field(~PAT, 1)));

    repeat (3) tick(0, 0, 0, 0);
    @(negedge tck);
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule